// File: doc/BRIEF.md
# Descriptor Queue Manager

This block keeps a set of hardware queues of 32-bit descriptor addresses behind a 32-bit register bus. All queues share one internal pool of link entries. A write to a queue's push register appends a descriptor at the tail. A read of the same register removes and returns the head. Each queue keeps a running descriptor count and a running byte count. A separate peek window reads both counts without disturbing the queue.

A packet size can travel with a push. Software either writes the size register and then the push register, or issues one 64-bit write that carries both words at once. One command word moves the whole content of one queue onto the tail or the head of another. It does this by relinking the lists, so no entry is copied. Each queue also has a threshold. A per-queue status output shows whether the queue holds at least that many descriptors.

Top module: `desc_queue_mgr`

## Requirements
- R1: Bus address bits 11:10 select the window (0 queue, 1 peek, 2 command, 3 unused), bits 4+ select the queue, and bits 3:2 select the word (0..3). Writing word 3 of the queue window appends the written address. Reading word 3 of the queue window returns the oldest entry and removes it. `busRvalid` and `busRdata` answer a read exactly one cycle later, and a write never produces `busRvalid`.
- R2: A non-wide write to word 2 of the queue window stores a size. The next word-3 push uses that size and then clears it. A word-3 push with no size stored before it carries size 0. A queue's byte count rises by the size of each push.
- R3: A wide write (`busWide`=1) to word 2 of the queue window pushes one entry in a single cycle. Bits 63:32 give the address and bits 31:0 give the size.
- R4: In the peek window, word 0 returns the descriptor count and word 1 returns the byte count. These reads change neither the queue nor the status output.
- R5: Reading word 3 of the queue window on an empty queue returns 0 and leaves both counts unchanged.
- R6: A pop lowers the byte count by the size stored with the removed entry.
- R7: A write to command word 0 with bit 31 = 0 moves every source entry (source queue in bits 15:0, destination queue in bits from 16) behind the destination's entries. The source becomes empty and the destination's counts become the sums. This also works when the destination is empty.
- R8: The same command with bit 31 = 1 places the source entries, in their order, ahead of the destination's entries.
- R9: A move whose source equals its destination, or whose source is empty, changes nothing.
- R10: Word 3 of the peek window is a per-queue threshold that can be written and read back. `qAbove[q]` is 1 exactly when the threshold is non-zero and the descriptor count is at or above it.
- R11: When all DEPTH link entries are in use, a push is dropped and the counts stay unchanged. Entries freed by pops can be used again.
- R12: After reset every queue is empty, every threshold is 0, `qAbove` is all zero and `busRvalid` is 0.
- R13: A read of an unused location returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| busValid | input | 1 | request strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | write carries 64 bits |
| busAddr | input | AW | byte address |
| busWdata | input | 64 | write data, low word used unless wide |
| busRvalid | output | 1 | read data valid |
| busRdata | output | 32 | read data |
| qAbove | output | NUM_Q | per-queue threshold status |

## Verification
The hardest case to reach is a push into an exhausted link pool. Every entry must be in use at once, and this only works if earlier pops and moves have given all entries back. The stimulus first drains every queue it has used, including the queues that received moves. It then fills a single queue to DEPTH entries, issues one more push, and drains that queue in order. This shows that the extra push was dropped and that the list order stayed intact.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic divert;
    logic divHead;
    logic setThr;
    logic peekCnt;
    logic peekBytes;
    logic peekThr;
  } dq_stb_t;

  localparam logic [1:0] WIN_QUEUE = 2'd0;
  localparam logic [1:0] WIN_PEEK  = 2'd1;
  localparam logic [1:0] WIN_CMD   = 2'd2;
endpackage

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 12,
  localparam int QW   = $clog2(NUM_Q),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic          busWide,
  input  logic [AW-1:0] busAddr,
  input  logic [63:0]   busWdata,
  output logic          busRvalid,
  output dq_stb_t       stb,
  output logic [QW-1:0] qSel,
  output logic [QW-1:0] qDst,
  output logic [31:0]   pushAddr,
  output logic [31:0]   pushSize,
  output logic [CW-1:0] thrVal
);
  logic [1:0]  win;
  logic [1:0]  word;
  logic [31:0] pendSize;
  logic        latchSize;

  assign win  = busAddr[AW-1:AW-2];
  assign word = busAddr[3:2];

  always_comb begin
    stb       = '0;
    latchSize = 1'b0;
    qSel      = busAddr[4 +: QW];
    qDst      = '0;
    pushAddr  = busWdata[31:0];
    pushSize  = pendSize;
    thrVal    = busWdata[CW-1:0];
    if (busValid) begin
      unique case (win)
        WIN_QUEUE: begin
          if (busWrite && word == 2'd2) begin
            if (busWide) begin
              stb.push = 1'b1;
              pushAddr = busWdata[63:32];
              pushSize = busWdata[31:0];
            end else begin
              latchSize = 1'b1;
            end
          end else if (word == 2'd3) begin
            stb.push = busWrite;
            stb.pop  = !busWrite;
          end
        end
        WIN_PEEK: begin
          if (busWrite) stb.setThr = (word == 2'd3);
          else begin
            stb.peekCnt   = (word == 2'd0);
            stb.peekBytes = (word == 2'd1);
            stb.peekThr   = (word == 2'd3);
          end
        end
        WIN_CMD: begin
          if (busWrite && busAddr[AW-3:0] == '0) begin
            stb.divert  = 1'b1;
            stb.divHead = busWdata[31];
            qSel        = busWdata[QW-1:0];
            qDst        = busWdata[16 +: QW];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendSize  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= busValid && !busWrite;
      if (latchSize) pendSize <= busWdata[31:0];
      else if (stb.push && !busWide) pendSize <= '0;
    end
  end
endmodule

// File: rtl/dq_datapath.sv
module dq_datapath
  import dq_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int DEPTH = 16,
  localparam int QW   = $clog2(NUM_Q),
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  dq_stb_t       stb,
  input  logic [QW-1:0] qSel,
  input  logic [QW-1:0] qDst,
  input  logic [31:0]   pushAddr,
  input  logic [31:0]   pushSize,
  input  logic [CW-1:0] thrVal,
  output logic [31:0]   rdData,
  output logic [NUM_Q-1:0] qAbove
);
  logic [31:0]   entAddr [DEPTH];
  logic [31:0]   entSize [DEPTH];
  logic [PW-1:0] nextPtr [DEPTH];
  logic [PW-1:0] headP   [NUM_Q];
  logic [PW-1:0] tailP   [NUM_Q];
  logic [CW-1:0] cnt     [NUM_Q];
  logic [31:0]   byteCnt [NUM_Q];
  logic [CW-1:0] thr     [NUM_Q];
  logic [PW-1:0] freeHead;
  logic [CW-1:0] freeCnt;
  logic [PW-1:0] slot;

  assign slot = stb.push ? freeHead : headP[qSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) nextPtr[i] <= PW'(i + 1);
      for (int q = 0; q < NUM_Q; q++) begin
        headP[q]   <= '0;
        tailP[q]   <= '0;
        cnt[q]     <= '0;
        byteCnt[q] <= '0;
        thr[q]     <= '0;
      end
      freeHead <= '0;
      freeCnt  <= CW'(DEPTH);
      rdData   <= '0;
    end else begin
      rdData <= '0;
      if (stb.push) begin
        if (freeCnt != '0) begin
          entAddr[slot] <= pushAddr;
          entSize[slot] <= pushSize;
          freeHead      <= nextPtr[slot];
          freeCnt       <= freeCnt - 1'b1;
          if (cnt[qSel] == '0) headP[qSel] <= slot;
          else nextPtr[tailP[qSel]] <= slot;
          tailP[qSel]   <= slot;
          cnt[qSel]     <= cnt[qSel] + 1'b1;
          byteCnt[qSel] <= byteCnt[qSel] + pushSize;
        end
      end else if (stb.pop) begin
        if (cnt[qSel] != '0) begin
          rdData        <= entAddr[slot];
          headP[qSel]   <= nextPtr[slot];
          cnt[qSel]     <= cnt[qSel] - 1'b1;
          byteCnt[qSel] <= byteCnt[qSel] - entSize[slot];
          nextPtr[slot] <= freeHead;
          freeHead      <= slot;
          freeCnt       <= freeCnt + 1'b1;
        end
      end else if (stb.divert) begin
        if (qSel != qDst && cnt[qSel] != '0) begin
          if (stb.divHead) begin
            if (cnt[qDst] != '0) nextPtr[tailP[qSel]] <= headP[qDst];
            else tailP[qDst] <= tailP[qSel];
            headP[qDst] <= headP[qSel];
          end else begin
            if (cnt[qDst] != '0) nextPtr[tailP[qDst]] <= headP[qSel];
            else headP[qDst] <= headP[qSel];
            tailP[qDst] <= tailP[qSel];
          end
          cnt[qDst]     <= cnt[qDst] + cnt[qSel];
          cnt[qSel]     <= '0;
          byteCnt[qDst] <= byteCnt[qDst] + byteCnt[qSel];
          byteCnt[qSel] <= '0;
        end
      end else if (stb.setThr) begin
        thr[qSel] <= thrVal;
      end else if (stb.peekCnt) begin
        rdData <= 32'(cnt[qSel]);
      end else if (stb.peekBytes) begin
        rdData <= byteCnt[qSel];
      end else if (stb.peekThr) begin
        rdData <= 32'(thr[qSel]);
      end
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_status
    assign qAbove[g] = (thr[g] != '0) && (cnt[g] >= thr[g]);
  end
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
  import dq_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 12,
  localparam int QW   = $clog2(NUM_Q),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic             busWide,
  input  logic [AW-1:0]    busAddr,
  input  logic [63:0]      busWdata,
  output logic             busRvalid,
  output logic [31:0]      busRdata,
  output logic [NUM_Q-1:0] qAbove
);
  dq_stb_t       stb;
  logic [QW-1:0] qSel;
  logic [QW-1:0] qDst;
  logic [31:0]   pushAddr;
  logic [31:0]   pushSize;
  logic [CW-1:0] thrVal;

  dq_ctrl #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .AW(AW)) ctrl_i (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busWide(busWide), .busAddr(busAddr), .busWdata(busWdata),
    .busRvalid(busRvalid), .stb(stb), .qSel(qSel), .qDst(qDst),
    .pushAddr(pushAddr), .pushSize(pushSize), .thrVal(thrVal)
  );

  dq_datapath #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .qSel(qSel), .qDst(qDst),
    .pushAddr(pushAddr), .pushSize(pushSize), .thrVal(thrVal),
    .rdData(busRdata), .qAbove(qAbove)
  );
endmodule

// File: rtl/desc_queue_mgr_chk.sv
module desc_queue_mgr_chk #(
  parameter int NUM_Q = 8,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             busValid,
  input logic             busWrite,
  input logic [AW-1:0]    busAddr,
  input logic             busRvalid,
  input logic [31:0]      busRdata,
  input logic [NUM_Q-1:0] qAbove
);
  a_r1_read_answers: assert property (@(posedge clk) disable iff (rst)
    busValid && !busWrite |=> busRvalid);

  a_r1_write_silent: assert property (@(posedge clk) disable iff (rst)
    !(busValid && !busWrite) |=> !busRvalid);

  a_r4_peek_keeps_status: assert property (@(posedge clk) disable iff (rst)
    busValid && !busWrite && busAddr[AW-1:AW-2] == 2'd1 |=> $stable(qAbove));

  a_r10_idle_holds_status: assert property (@(posedge clk) disable iff (rst)
    !busValid |=> $stable(qAbove));

  a_r13_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
    busValid && !busWrite && busAddr[AW-1:AW-2] == 2'd3 |=> busRdata == 32'd0);

  a_r12_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> qAbove == '0 && !busRvalid);
endmodule

bind desc_queue_mgr desc_queue_mgr_chk #(.NUM_Q(NUM_Q), .AW(AW)) chk_i (.*);

// File: tb/desc_queue_mgr_tb_top.sv
module desc_queue_mgr_tb_top;
  localparam int NUM_Q = 8;
  localparam int DEPTH = 16;
  localparam int AW    = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             busValid = 1'b0;
  logic             busWrite = 1'b0;
  logic             busWide = 1'b0;
  logic [AW-1:0]    busAddr = '0;
  logic [63:0]      busWdata = '0;
  logic             busRvalid;
  logic [31:0]      busRdata;
  logic [NUM_Q-1:0] qAbove;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  desc_queue_mgr #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .AW(AW)) dut_i (.*);

  function automatic logic [AW-1:0] qa(input int q, input int w);
    return AW'(q * 16 + w * 4);
  endfunction
  function automatic logic [AW-1:0] pk(input int q, input int w);
    return AW'(12'h400 + q * 16 + w * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic wide = 1'b0);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busWide = wide; busAddr = a; busWdata = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busWide = 1'b0; busAddr = a; busWdata = '0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      busValid = 1'b0; busWrite = 1'b0; busWide = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: compare read responses against the scoreboard
  always @(negedge clk) begin
    if (!rst && busRvalid) begin
      if (expQ.size() == 0) begin
        check("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        check(tagQ.pop_front(), busRdata, expQ.pop_front());
      end
    end
  end

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 rvalid after reset", 32'(busRvalid), 32'd0);
    check("R12 status after reset", 32'(qAbove), 32'd0);
    rd(pk(0, 0), 32'd0, "R12 count after reset");

    // R1 R2 R3: three push styles into queue 1
    wr(qa(1, 3), 64'h1000);
    wr(qa(1, 2), 64'h40);
    wr(qa(1, 3), 64'h2000);
    wr(qa(1, 2), {32'h3000, 32'h80}, 1'b1);
    rd(pk(1, 0), 32'd3, "R1 count");
    rd(pk(1, 1), 32'hC0, "R2 R3 bytes");
    rd(pk(1, 0), 32'd3, "R4 peek is harmless");
    rd(qa(1, 3), 32'h1000, "R1 pop order 1");
    rd(qa(1, 3), 32'h2000, "R1 pop order 2");
    rd(pk(1, 1), 32'h80, "R6 bytes after pop");
    rd(qa(1, 3), 32'h3000, "R3 wide address");
    rd(pk(1, 1), 32'h0, "R6 bytes empty");
    rd(qa(1, 3), 32'h0, "R5 empty pop");
    rd(pk(1, 0), 32'd0, "R5 count stays");
    rd(pk(1, 1), 32'd0, "R5 bytes stay");

    // R7 tail move 3 -> 2
    wr(qa(2, 2), {32'hA1, 32'd1}, 1'b1);
    wr(qa(2, 2), {32'hA2, 32'd2}, 1'b1);
    wr(qa(3, 2), {32'hB1, 32'd4}, 1'b1);
    wr(12'h800, 64'h0002_0003);
    rd(pk(2, 0), 32'd3, "R7 dest count");
    rd(pk(2, 1), 32'd7, "R7 dest bytes");
    rd(pk(3, 0), 32'd0, "R7 source empty");
    rd(pk(3, 1), 32'd0, "R7 source bytes");
    rd(qa(2, 3), 32'hA1, "R7 order 1");
    rd(qa(2, 3), 32'hA2, "R7 order 2");
    rd(qa(2, 3), 32'hB1, "R7 order 3");

    // R8 head move 5 -> 4
    wr(qa(4, 3), 64'hC1);
    wr(qa(4, 3), 64'hC2);
    wr(qa(5, 3), 64'hD1);
    wr(qa(5, 3), 64'hD2);
    wr(12'h800, 64'h8004_0005);
    rd(pk(5, 0), 32'd0, "R8 source empty");
    rd(pk(4, 0), 32'd4, "R8 dest count");
    rd(qa(4, 3), 32'hD1, "R8 order 1");
    rd(qa(4, 3), 32'hD2, "R8 order 2");
    rd(qa(4, 3), 32'hC1, "R8 order 3");
    rd(qa(4, 3), 32'hC2, "R8 order 4");

    // R7 move into an empty destination
    wr(qa(6, 3), 64'hE1);
    wr(12'h800, 64'h0007_0006);
    rd(qa(7, 3), 32'hE1, "R7 empty dest");
    rd(pk(6, 0), 32'd0, "R7 empty dest source");

    // R9 self move and empty source
    wr(qa(0, 2), {32'hF1, 32'd9}, 1'b1);
    wr(12'h800, 64'h0000_0000);
    rd(pk(0, 0), 32'd1, "R9 self move count");
    rd(pk(0, 1), 32'd9, "R9 self move bytes");
    wr(12'h800, 64'h8000_0001);
    rd(pk(0, 0), 32'd1, "R9 empty source");
    rd(qa(0, 3), 32'hF1, "R9 entry intact");

    // R10 threshold
    wr(pk(3, 3), 64'd2);
    rd(pk(3, 3), 32'd2, "R10 readback");
    idle(1);
    check("R10 below", 32'(qAbove[3]), 32'd0);
    wr(qa(3, 3), 64'h51);
    idle(1);
    check("R10 one entry", 32'(qAbove[3]), 32'd0);
    wr(qa(3, 3), 64'h52);
    idle(1);
    check("R10 at threshold", 32'(qAbove[3]), 32'd1);
    wr(qa(3, 3), 64'h53);
    idle(1);
    check("R10 above", 32'(qAbove[3]), 32'd1);
    rd(qa(3, 3), 32'h51, "R10 pop");
    rd(qa(3, 3), 32'h52, "R10 pop");
    idle(1);
    check("R10 fell below", 32'(qAbove[3]), 32'd0);
    check("R10 other queues", 32'(qAbove & 8'hF7), 32'd0);
    rd(qa(3, 3), 32'h53, "R10 drain");

    // R11 exhaust the pool
    for (int i = 0; i < DEPTH; i++) wr(qa(0, 3), 64'(32'h100 + i));
    wr(qa(0, 2), {32'h999, 32'd5}, 1'b1);
    rd(pk(0, 0), 32'(DEPTH), "R11 count at full");
    rd(pk(0, 1), 32'd0, "R11 bytes unchanged");
    for (int i = 0; i < DEPTH; i++) rd(qa(0, 3), 32'h100 + 32'(i), "R11 order");
    rd(qa(0, 3), 32'd0, "R11 dropped push");
    wr(qa(5, 3), 64'h77);
    rd(qa(5, 3), 32'h77, "R11 slot reuse");

    // R13 unused window
    rd(12'hC00, 32'd0, "R13 unused read");
    rd(qa(2, 0), 32'd0, "R13 unused word");

    idle(4);
    check("R1 all responses seen", 32'(expQ.size()), 32'd0);
    finishRun();
  end
endmodule